// File: doc/BRIEF.md
# Grouped Interrupt Request Encoder

The block collects interrupt requests from three groups: a critical group of 4 lines, a main group of 17 lines and a peripheral group of 32 lines. Each cycle it samples the request lines and applies the mask registers. It then publishes one encoded status word that carries a valid flag and the lowest active source number for each group. Peripheral source 0 does not come from a pin. It is the summary of a 32-bit DMA event word, which the block keeps as a sticky pending register with its own mask.

The groups are chained. Main source 4 is driven inside the block with the peripheral group's valid flag, and critical source 2 is reserved for high-priority peripheral traffic. No such traffic exists without programmable priorities, so source 2 is held inactive. From the status word the block also resolves one interrupt vector and drives a single request line. The vector holds a 2-bit class in bits [7:6] (0 critical, 1 main, 2 peripheral, 3 DMA) and a 6-bit source number in bits [5:0]. Software reaches the masks and the DMA registers through a single-cycle word-addressed port with a combinational read.

Top module: `irqenc_top`

## Requirements
- R1: After reset, the peripheral mask reads 0x7FFFFC00, the main mask reads 0x00010FFF, the DMA mask reads 0xFFFFFFFF and the DMA pending word reads 0. The status word, `irq_out` and `irq_vec` are all 0.
- R2: The main mask is at word offset 1. It has 17 bits. A set bit disables the source it belongs to: bit 15-n for main source n (n from 0 to 15), and bit 16 for main source 16.
- R3: The peripheral mask is at word offset 0. A set bit 31-n disables peripheral source n.
- R4: The status word gives each group's lowest-numbered active, unmasked source. The critical group uses bit 10 for valid and bits [9:8] for the source. The main group uses bit 21 and bits [20:16]. The peripheral group uses bit 29 and bits [28:24]. All other bits are 0, and a field whose group is not valid reads 0.
- R5: Peripheral source 0 is active when any bit of (DMA pending AND NOT DMA mask) is set. Input `periph_req[0]` has no effect.
- R6: The DMA pending word is at word offset 3. Each `dma_evt` bit sets its pending bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: The DMA mask is at word offset 4, and a set bit disables that DMA bit. A masked event is still recorded in the pending word.
- R8: Main source 4 is active exactly when the peripheral group is valid, and `main_req[4]` has no effect. Critical source 2 is never active, and `crit_req[2]` has no effect.
- R9: `irq_out` is high exactly when at least one of the three group-valid flags is set.
- R10: `irq_vec` takes its value from the first case that applies, in this order: critical valid gives {0, critical source}; main valid with a source other than 4 gives {1, main source}; any other state with the peripheral group valid gives {2, peripheral source} for sources other than 0, or {3, lowest unmasked pending DMA bit} for source 0. When no group is valid, `irq_vec` is 0.
- R11: Request lines, DMA events and register writes reach the status word, `irq_out` and `irq_vec` one cycle after the clock edge at which they are sampled.
- R12: Reading word offset 2 returns the status word. Writes to offset 2 have no effect. Offsets 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crit_req | input | 4 | Critical group request lines |
| main_req | input | 17 | Main group request lines |
| periph_req | input | 32 | Peripheral group request lines (bit 0 unused) |
| dma_evt | input | 32 | DMA event pulses, one per pending bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| enc_status | output | 32 | Encoded group status word |
| irq_out | output | 1 | Interrupt request line |
| irq_vec | output | 8 | Resolved vector: class in [7:6], source in [5:0] |

## Verification
The assertions assume that the inputs are 2-state and stable around each rising edge. They also assume that reset is released away from an edge, so the sampled request registers and the DMA pending word always start from their reset values. The bench changes every input just after a falling edge and releases reset in the same way. Its random phase keeps the DMA events sparse and picks any of the eight offsets, unmapped ones included. The pending-register properties therefore see same-cycle events and clears without ever seeing an input that is unknown.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

    // Register word offsets
    localparam logic [2:0] OFS_PMASK = 3'd0;
    localparam logic [2:0] OFS_MMASK = 3'd1;
    localparam logic [2:0] OFS_STAT  = 3'd2;
    localparam logic [2:0] OFS_DPEND = 3'd3;
    localparam logic [2:0] OFS_DMASK = 3'd4;

    // Reserved sources that chain a group onward to the peripheral group
    localparam int FWD_CRIT_SRC = 2;
    localparam int FWD_MAIN_SRC = 4;

    // Vector class codes carried in irq_vec[7:6]
    typedef enum logic [1:0] {
        CLS_CRIT = 2'd0,
        CLS_MAIN = 2'd1,
        CLS_PERI = 2'd2,
        CLS_DMA  = 2'd3
    } irq_class_e;

endpackage

// File: rtl/irqenc_lsb.sv
module irqenc_lsb #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);

    // Scan downward so that the lowest set index is the last one written
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end

endmodule

// File: rtl/irqenc_regs.sv
module irqenc_regs
    import irqenc_pkg::*;
#(
    parameter int          NPER       = 32,
    parameter int          NMAIN      = 17,
    parameter int          NDMA       = 32,
    parameter int          DW         = 32,
    parameter int          AW         = 3,
    parameter logic [31:0] PMASK_INIT = 32'h7fff_fc00,
    parameter logic [31:0] MMASK_INIT = 32'h0001_0fff
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [NDMA-1:0]  dma_evt,
    input  logic [DW-1:0]    stat_word,
    output logic [DW-1:0]    rdata,
    output logic [NPER-1:0]  pmask,
    output logic [NMAIN-1:0] mmask,
    output logic [NDMA-1:0]  dmask,
    output logic [NDMA-1:0]  dpend
);

    logic [NDMA-1:0] clr_bits;

    assign clr_bits = (we && addr == OFS_DPEND) ? wdata[NDMA-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask <= PMASK_INIT[NPER-1:0];
            mmask <= MMASK_INIT[NMAIN-1:0];
            dmask <= '1;
            dpend <= '0;
        end else begin
            if (we && addr == OFS_PMASK) pmask <= wdata[NPER-1:0];
            if (we && addr == OFS_MMASK) mmask <= wdata[NMAIN-1:0];
            if (we && addr == OFS_DMASK) dmask <= wdata[NDMA-1:0];
            // a new event outranks a same-cycle clear
            dpend <= (dpend & ~clr_bits) | dma_evt;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_PMASK: rdata = DW'(pmask);
            OFS_MMASK: rdata = DW'(mmask);
            OFS_STAT:  rdata = stat_word;
            OFS_DPEND: rdata = DW'(dpend);
            OFS_DMASK: rdata = DW'(dmask);
            default:   rdata = '0;
        endcase
    end

    // R6
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt != '0) |=> ((dpend & $past(dma_evt)) == $past(dma_evt)));

    // R6
    pend_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dpend & ~$past(dpend) & ~$past(dma_evt)) == '0));

endmodule

// File: rtl/irqenc_top.sv
module irqenc_top
    import irqenc_pkg::*;
#(
    parameter int          NCRIT      = 4,
    parameter int          NMAIN      = 17,
    parameter int          NPER       = 32,
    parameter int          NDMA       = 32,
    parameter int          DW         = 32,
    parameter int          AW         = 3,
    parameter logic [31:0] PMASK_INIT = 32'h7fff_fc00,
    parameter logic [31:0] MMASK_INIT = 32'h0001_0fff
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCRIT-1:0] crit_req,
    input  logic [NMAIN-1:0] main_req,
    input  logic [NPER-1:0]  periph_req,
    input  logic [NDMA-1:0]  dma_evt,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [DW-1:0]    enc_status,
    output logic             irq_out,
    output logic [7:0]       irq_vec
);

    localparam int CW = $clog2(NCRIT);
    localparam int MW = $clog2(NMAIN);
    localparam int PW = $clog2(NPER);
    localparam int DWI = $clog2(NDMA);

    logic [NCRIT-1:0] crit_q, crit_eff;
    logic [NMAIN-1:0] main_q, main_eff, mmask;
    logic [NPER-1:0]  per_q, per_eff, pmask;
    logic [NDMA-1:0]  dmask, dpend, dma_live;
    logic             dma_any;
    logic             crit_v, main_v, per_v, dma_v;
    logic [CW-1:0]    crit_s;
    logic [MW-1:0]    main_s;
    logic [PW-1:0]    per_s;
    logic [DWI-1:0]   dma_s;
    irq_class_e       vec_cls;
    logic [5:0]       vec_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crit_q <= '0;
            main_q <= '0;
            per_q  <= '0;
        end else begin
            crit_q <= crit_req;
            main_q <= main_req;
            per_q  <= periph_req;
        end
    end

    irqenc_regs #(
        .NPER(NPER), .NMAIN(NMAIN), .NDMA(NDMA), .DW(DW), .AW(AW),
        .PMASK_INIT(PMASK_INIT), .MMASK_INIT(MMASK_INIT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .dma_evt(dma_evt), .stat_word(enc_status),
        .rdata(reg_rdata), .pmask(pmask), .mmask(mmask),
        .dmask(dmask), .dpend(dpend)
    );

    assign dma_live = dpend & ~dmask;
    assign dma_any  = |dma_live;

    // Effective request vectors, built per source
    for (genvar c = 0; c < NCRIT; c++) begin : g_crit
        if (c == FWD_CRIT_SRC) begin : g_rsv
            assign crit_eff[c] = 1'b0;
        end else begin : g_pin
            assign crit_eff[c] = crit_q[c];
        end
    end

    for (genvar p = 0; p < NPER; p++) begin : g_per
        if (p == 0) begin : g_dma
            assign per_eff[p] = dma_any & ~pmask[NPER-1-p];
        end else begin : g_pin
            assign per_eff[p] = per_q[p] & ~pmask[NPER-1-p];
        end
    end

    for (genvar m = 0; m < NMAIN; m++) begin : g_main
        localparam int MB = (m < NMAIN - 1) ? (NMAIN - 2 - m) : (NMAIN - 1);
        if (m == FWD_MAIN_SRC) begin : g_fwd
            assign main_eff[m] = per_v & ~mmask[MB];
        end else begin : g_pin
            assign main_eff[m] = main_q[m] & ~mmask[MB];
        end
    end

    irqenc_lsb #(.N(NCRIT)) crit_enc_i (.req(crit_eff), .hit(crit_v), .idx(crit_s));
    irqenc_lsb #(.N(NMAIN)) main_enc_i (.req(main_eff), .hit(main_v), .idx(main_s));
    irqenc_lsb #(.N(NPER))  per_enc_i  (.req(per_eff),  .hit(per_v),  .idx(per_s));
    irqenc_lsb #(.N(NDMA))  dma_enc_i  (.req(dma_live), .hit(dma_v),  .idx(dma_s));

    always_comb begin
        enc_status        = '0;
        enc_status[10]    = crit_v;
        enc_status[9:8]   = 2'(crit_s);
        enc_status[21]    = main_v;
        enc_status[20:16] = 5'(main_s);
        enc_status[29]    = per_v;
        enc_status[28:24] = 5'(per_s);
    end

    assign irq_out = crit_v | main_v | per_v;

    // Vector resolution: critical, then main, then peripheral (DMA via source 0)
    always_comb begin
        vec_cls = CLS_CRIT;
        vec_src = '0;
        if (crit_v) begin
            vec_cls = CLS_CRIT;
            vec_src = 6'(crit_s);
        end else if (main_v && main_s != MW'(FWD_MAIN_SRC)) begin
            vec_cls = CLS_MAIN;
            vec_src = 6'(main_s);
        end else if (per_v) begin
            if (per_s == '0) begin
                vec_cls = CLS_DMA;
                vec_src = 6'(dma_s);
            end else begin
                vec_cls = CLS_PERI;
                vec_src = 6'(per_s);
            end
        end
    end

    assign irq_vec = {vec_cls, vec_src};

    // R4
    per_field_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_status[29] |-> per_eff[enc_status[28:24]]);

    // R8
    crit_rsv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_status[10] |-> (enc_status[9:8] != 2'd2));

    // R8
    main_fwd_needs_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_status[21] && enc_status[20:16] == 5'd4) |-> enc_status[29]);

    // R10
    vec_no_fwd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_vec != 8'h44));

    // R10
    vec_dma_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec[7:6] == 2'd3) |-> (enc_status[29] && enc_status[28:24] == 5'd0
                                     && dpend[irq_vec[4:0]]));

endmodule

// File: tb/irqenc_top_tb_top.sv
module irqenc_top_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  crit_req = '0;
    logic [16:0] main_req = '0;
    logic [31:0] periph_req = '0;
    logic [31:0] dma_evt = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, enc_status;
    logic        irq_out;
    logic [7:0]  irq_vec;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    irqenc_top dut_i (
        .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
        .periph_req(periph_req), .dma_evt(dma_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .enc_status(enc_status), .irq_out(irq_out), .irq_vec(irq_vec)
    );

    // Behavioural reference state
    logic [3:0]  m_crit = '0;
    logic [16:0] m_main = '0;
    logic [31:0] m_per = '0;
    logic [31:0] m_pmask = 32'h7fff_fc00;
    logic [16:0] m_mmask = 17'h1_0fff;
    logic [31:0] m_dmask = 32'hffff_ffff;
    logic [31:0] m_dpend = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_crit <= '0; m_main <= '0; m_per <= '0;
            m_pmask <= 32'h7fff_fc00; m_mmask <= 17'h1_0fff;
            m_dmask <= 32'hffff_ffff; m_dpend <= '0;
        end else begin
            m_crit <= crit_req; m_main <= main_req; m_per <= periph_req;
            if (reg_we && reg_addr == 3'd0) m_pmask <= reg_wdata;
            if (reg_we && reg_addr == 3'd1) m_mmask <= reg_wdata[16:0];
            if (reg_we && reg_addr == 3'd4) m_dmask <= reg_wdata;
            m_dpend <= (m_dpend & ~((reg_we && reg_addr == 3'd3) ? reg_wdata : 32'h0)) | dma_evt;
        end
    end

    task automatic model_eval(output logic [31:0] st, output logic irq,
                              output logic [7:0] vec, output logic [31:0] rd);
        bit dany, cv, mv, pv, dv;
        int cs, ms, ps, ds;
        dany = |(m_dpend & ~m_dmask);
        cv = 0; cs = 0; pv = 0; ps = 0; mv = 0; ms = 0; dv = 0; ds = 0;
        for (int i = 3; i >= 0; i--)
            if (i != 2 && m_crit[i]) begin cv = 1; cs = i; end
        for (int i = 31; i >= 0; i--)
            if (((i == 0) ? dany : m_per[i]) && !m_pmask[31-i]) begin pv = 1; ps = i; end
        for (int i = 16; i >= 0; i--)
            if (((i == 4) ? pv : m_main[i]) && !m_mmask[(i == 16) ? 16 : 15-i]) begin mv = 1; ms = i; end
        for (int i = 31; i >= 0; i--)
            if (m_dpend[i] && !m_dmask[i]) begin dv = 1; ds = i; end
        st = '0;
        st[10] = cv; st[9:8] = cs[1:0];
        st[21] = mv; st[20:16] = ms[4:0];
        st[29] = pv; st[28:24] = ps[4:0];
        irq = cv | mv | pv;
        if (cv) vec = {2'd0, cs[5:0]};
        else if (mv && ms != 4) vec = {2'd1, ms[5:0]};
        else if (pv) vec = (ps == 0) ? {2'd3, ds[5:0]} : {2'd2, ps[5:0]};
        else vec = 8'h00;
        case (reg_addr)
            3'd0: rd = m_pmask;
            3'd1: rd = {15'h0, m_mmask};
            3'd2: rd = st;
            3'd3: rd = m_dpend;
            3'd4: rd = m_dmask;
            default: rd = '0;
        endcase
    endtask

    task automatic expect32(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock; compare every output against the model at the falling edge
    task automatic tick(string req);
        logic [31:0] st, rd;
        logic irq;
        logic [7:0] vec;
        @(posedge clk);
        @(negedge clk);
        model_eval(st, irq, vec, rd);
        expect32({req, "/R4"}, "enc_status", enc_status, st);
        expect32({req, "/R9"}, "irq_out", {31'h0, irq_out}, {31'h0, irq});
        expect32({req, "/R10"}, "irq_vec", {24'h0, irq_vec}, {24'h0, vec});
        expect32({req, "/R12"}, "reg_rdata", reg_rdata, rd);
    endtask

    task automatic wr(string req, logic [2:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(req);
        reg_we = 1'b0;
    endtask

    task automatic rd_expect(string req, logic [2:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        expect32(req, "read", reg_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick("R1");
        @(negedge clk);
        rst_n = 1'b1;
        tick("R1");
        rd_expect("R1", 3'd0, 32'h7fff_fc00);
        rd_expect("R1", 3'd1, 32'h0001_0fff);
        rd_expect("R1", 3'd3, 32'h0000_0000);
        rd_expect("R1", 3'd4, 32'hffff_ffff);
        expect32("R1", "status", enc_status, 32'h0);
        expect32("R1", "irq_out", {31'h0, irq_out}, 32'h0);

        // R11 / R4: critical sources 1 and 3, lowest reported one cycle later
        crit_req = 4'b1010;
        tick("R11");
        expect32("R11", "crit status", enc_status, 32'h0000_0500);
        expect32("R10", "crit vec", {24'h0, irq_vec}, 32'h01);
        // R8: reserved critical and main forwarding pins have no effect
        crit_req = 4'b0100;
        main_req = 17'h0_0010;
        tick("R8");
        expect32("R8", "ignored pins", enc_status, 32'h0);
        expect32("R8", "irq_out", {31'h0, irq_out}, 32'h0);
        crit_req = '0; main_req = '0;

        // R2: main mask, reversed bit order
        wr("R2", 3'd1, 32'h0);
        main_req = 17'h0_0020;
        tick("R2");
        expect32("R2", "main src5", enc_status, 32'h0005_0000 | 32'h0020_0000);
        expect32("R10", "main vec", {24'h0, irq_vec}, 32'h45);
        wr("R2", 3'd1, 32'h0000_0400);
        tick("R2");
        expect32("R2", "main src5 masked", enc_status, 32'h0);
        main_req = 17'h1_0000;
        wr("R2", 3'd1, 32'h0001_0000);
        tick("R2");
        expect32("R2", "main src16 masked", {31'h0, irq_out}, 32'h0);
        main_req = '0;
        wr("R2", 3'd1, 32'h0);

        // R3 / R8: peripheral source 7, forwarded through main source 4
        wr("R3", 3'd0, 32'h0);
        periph_req = 32'h0000_0081;
        tick("R3");
        expect32("R3", "per src7", enc_status, 32'h2724_0000);
        expect32("R10", "fwd vec", {24'h0, irq_vec}, 32'h87);
        wr("R3", 3'd0, 32'h0100_0000);
        tick("R3");
        expect32("R5", "per src0 pin ignored", enc_status, 32'h0);
        periph_req = '0;

        // R5 / R6 / R7: DMA pending and mask
        wr("R7", 3'd4, 32'h0);
        dma_evt = 32'h0000_0200;
        tick("R6");
        dma_evt = '0;
        tick("R5");
        expect32("R5", "dma via per0", enc_status, 32'h2024_0000);
        expect32("R10", "dma vec", {24'h0, irq_vec}, 32'hc9);
        dma_evt = 32'h0000_0008;
        tick("R6");
        dma_evt = 32'h0000_0008;
        wr("R6", 3'd3, 32'h0000_0008);
        dma_evt = '0;
        rd_expect("R6", 3'd3, 32'h0000_0208);
        wr("R6", 3'd3, 32'h0000_0008);
        rd_expect("R6", 3'd3, 32'h0000_0200);
        wr("R7", 3'd4, 32'h0000_0200);
        tick("R7");
        rd_expect("R7", 3'd3, 32'h0000_0200);
        expect32("R7", "dma masked", {31'h0, irq_out}, 32'h0);
        wr("R12", 3'd2, 32'hffff_ffff);
        rd_expect("R12", 3'd2, 32'h0);
        rd_expect("R12", 3'd6, 32'h0);

        // Mixed random traffic compared every cycle
        for (int n = 0; n < 1500; n++) begin
            crit_req = 4'($urandom);
            main_req = 17'($urandom & $urandom);
            periph_req = $urandom & $urandom & $urandom;
            dma_evt = $urandom & $urandom & $urandom & $urandom;
            reg_addr = 3'($urandom);
            reg_we = ($urandom % 6) == 0;
            reg_wdata = $urandom;
            if (n % 5 == 0) crit_req = '0;
            tick("R10");
        end
        reg_we = 1'b0;
        tick("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule